// File: doc/BRIEF.md
# Pipelined SPI Register Slave

This block lets a host reach a bank of 16-bit registers over a four-wire serial link. Each frame is 16 bits, sent MSB first in clock mode 3. The top bit of a frame says whether it writes. The next seven bits give a byte address, and on a write the low eight bits carry one byte. Each register occupies two byte addresses: the even one selects the low byte for writes and the odd one the high byte. A read of either address returns the whole word. That word does not come back in the frame that asked for it. It shifts out during the following frame.

The serial pins are synchronised into a system clock that runs at least eight times faster than the serial clock. Register storage lives outside the block and is reached through a simple parallel port: a one-cycle write strobe with a word index, a byte-lane select and a byte, plus a read index with combinational read data. The block holds one register itself, a command word at byte addresses 0x3E/0x3F. Writing a 1 to any of its bits starts that action, and the bit clears when the requester reports the action done. Two sticky error flags report framing faults and accesses made while a capture is busy. The serial output is high-impedance whenever chip select is high.

Top module: `spi_regslave`

## Requirements
- R1: The link uses mode 3. `sdi` is sampled on rising `sclk` edges and `sdo` changes on falling edges, MSB first. Consecutive 16-bit frames may share one chip-select assertion.
- R2: Frame bit 15 = 1 marks a write, bits 14:8 the byte address, bits 7:0 the byte. A write to a mapped word pulses `reg_wr_en` once with `reg_wr_idx` = address[6:1], `reg_wr_hi` = address[0] and the byte.
- R3: A read frame selects a word, and its full value shifts out on `sdo` during the next frame. The even and odd byte addresses of a word return the same value.
- R4: A write frame does not change the read selection. The frame after a write returns the word from the last completed read, which is word 0 after reset.
- R5: `sdo` is high-impedance whenever `cs_n` is high.
- R6: `err_len` is set when `cs_n` rises after a count of rising `sclk` edges that is not a multiple of 16. A frame cut short in this way commits no write.
- R7: `err_busy` is set whenever `cs_n` is low while `capture_busy` is high.
- R8: Writing byte address 0x3F with 0x08 (frame 0xBF08) pulses `cmd_start[11]` for one cycle and sets pending bit 11. The bit reads back in the command word (0x3E/0x3F) until `cmd_done[11]` is seen. A new set and a `cmd_done` on the same bit in the same cycle leave the bit set.
- R9: Command bit 4 (frame 0xBE10) clears both error flags and is never left pending. If a flag's set condition occurs in the same cycle, the flag stays set.
- R10: Word indices 24 and above, other than the command word 31, read back 0x0000, and writes to them pulse no `reg_wr_en`.
- R11: After reset, both error flags, `cmd_start` and the command word are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock, idles high |
| cs_n | input | 1 | Active-low chip select |
| sdi | input | 1 | Serial data from host |
| sdo | output | 1 | Serial data to host, Z when deselected |
| capture_busy | input | 1 | High while a capture runs |
| cmd_done | input | 16 | Per-bit completion of command actions |
| cmd_start | output | 16 | One-cycle start pulse per command bit |
| err_len | output | 1 | Sticky framing-length error |
| err_busy | output | 1 | Sticky access-while-busy error |
| reg_wr_en | output | 1 | Register-file byte write strobe |
| reg_wr_idx | output | 6 | Word index of the write |
| reg_wr_hi | output | 1 | 1 = high byte lane, 0 = low byte lane |
| reg_wr_byte | output | 8 | Byte to write |
| reg_rd_idx | output | 6 | Word index being read |
| reg_rd_data | input | 16 | Register-file word at `reg_rd_idx` |

## Verification
Two things can land on the same pending command bit in one system cycle: a fresh write that commits a set, and a `cmd_done` that clears the bit. The bench holds `cmd_done[11]` high across a 0xBF08 frame. It drops that input only after it observes the `cmd_start[11]` pulse, then reads the command word back, which must still show bit 11. In the same way, a busy-error set and the error-clear command coincide when 0xBE10 is sent while `capture_busy` stays high, and `err_busy` must remain set.

// File: rtl/spi_regslave_pkg.sv
`timescale 1ns/1ps
package spi_regslave_pkg;
  localparam int ADDR_W = 7;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 16;
  localparam int WIDX_W = ADDR_W - 1;
  localparam int CNT_W  = $clog2(WORD_W);

  typedef struct packed {
    logic              wr;
    logic [ADDR_W-1:0] addr;
    logic [BYTE_W-1:0] data;
  } frame_t;

  // byte placed into its lane of a word
  function automatic logic [WORD_W-1:0] byte_lane_mask(input logic hi, input logic [BYTE_W-1:0] b);
    return hi ? {b, BYTE_W'(0)} : {BYTE_W'(0), b};
  endfunction

  // a frame boundary is reached when the edge counter wrapped to zero
  function automatic logic frame_aligned(input logic [CNT_W-1:0] cnt);
    return cnt == '0;
  endfunction

  function automatic logic last_bit(input logic [CNT_W-1:0] cnt);
    return cnt == CNT_W'(WORD_W - 1);
  endfunction
endpackage

// File: rtl/spi_sync.sv
`timescale 1ns/1ps
module spi_sync #(
  parameter int           W       = 3,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) pipe[0] <= RST_VAL;
          else        pipe[0] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) pipe[s] <= RST_VAL;
          else        pipe[s] <= pipe[s-1];
      end
    end
  endgenerate

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/spi_frame_shift.sv
`timescale 1ns/1ps
module spi_frame_shift
  import spi_regslave_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_s,
  input  logic              cs_n_s,
  input  logic              sdi_s,
  input  logic              ld_en,
  input  logic [WORD_W-1:0] ld_word,
  output logic              frame_done,
  output logic [WORD_W-1:0] frame_word,
  output logic              cs_fall,
  output logic              len_bad,
  output logic              cs_active,
  output logic              sdo_bit
);
  logic              sclk_d, cs_d;
  logic              sck_rise, sck_fall, cs_rise;
  logic [CNT_W-1:0]  bit_cnt;
  logic [WORD_W-1:0] rx_sh, tx_sh;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sclk_d <= 1'b1;
      cs_d   <= 1'b1;
    end else begin
      sclk_d <= sclk_s;
      cs_d   <= cs_n_s;
    end

  assign cs_active = ~cs_n_s;
  assign sck_rise  = sclk_s & ~sclk_d & cs_active;
  assign sck_fall  = ~sclk_s & sclk_d & cs_active;
  assign cs_fall   = cs_d & ~cs_n_s;
  assign cs_rise   = ~cs_d & cs_n_s;

  assign frame_done = sck_rise & last_bit(bit_cnt);
  assign frame_word = {rx_sh[WORD_W-2:0], sdi_s};
  assign len_bad    = cs_rise & ~frame_aligned(bit_cnt);

  // receive side: counter and shifter on rising edges
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bit_cnt <= '0;
      rx_sh   <= '0;
    end else if (cs_fall) begin
      bit_cnt <= '0;
    end else if (sck_rise) begin
      bit_cnt <= bit_cnt + 1'b1;
      rx_sh   <= frame_word;
    end

  // transmit side: load wins, else advance on falling edges
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_sh   <= '0;
      sdo_bit <= 1'b0;
    end else if (ld_en) begin
      tx_sh   <= ld_word;
      sdo_bit <= ld_word[WORD_W-1];
    end else if (sck_fall) begin
      sdo_bit <= tx_sh[WORD_W-1];
      tx_sh   <= {tx_sh[WORD_W-2:0], 1'b0};
    end

  // R1: the counter wraps to a frame boundary after each 16th edge
  assert_cnt_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> frame_aligned(bit_cnt));
endmodule

// File: rtl/spi_reg_decode.sv
`timescale 1ns/1ps
module spi_reg_decode
  import spi_regslave_pkg::*;
#(
  parameter int NUM_WORDS = 24,
  parameter int CMD_WORD  = 31,
  parameter int CLR_BIT   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_done,
  input  logic [WORD_W-1:0] frame_word,
  input  logic              cs_fall,
  input  logic              len_bad,
  input  logic              cs_active,
  input  logic              capture_busy,
  input  logic [WORD_W-1:0] cmd_done,
  input  logic [WORD_W-1:0] reg_rd_data,
  output logic              reg_wr_en,
  output logic [WIDX_W-1:0] reg_wr_idx,
  output logic              reg_wr_hi,
  output logic [BYTE_W-1:0] reg_wr_byte,
  output logic [WIDX_W-1:0] reg_rd_idx,
  output logic [WORD_W-1:0] cmd_start,
  output logic              err_len,
  output logic              err_busy,
  output logic              ld_en,
  output logic [WORD_W-1:0] ld_word
);
  localparam logic [WIDX_W-1:0] NUM_IDX  = WIDX_W'(NUM_WORDS);
  localparam logic [WIDX_W-1:0] CMD_IDX  = WIDX_W'(CMD_WORD);
  localparam logic [WORD_W-1:0] CLR_MASK = WORD_W'(1) << CLR_BIT;

  frame_t            fr;
  logic [WIDX_W-1:0] widx;
  logic              is_cmd, is_mapped, wr_commit, clr_req;
  logic [WORD_W-1:0] set_mask, cmd_pend;
  logic [WIDX_W-1:0] rd_idx_q;

  assign fr        = frame_t'(frame_word);
  assign widx      = fr.addr[ADDR_W-1:1];
  assign is_cmd    = widx == CMD_IDX;
  assign is_mapped = (widx < NUM_IDX) && !is_cmd;
  assign wr_commit = frame_done & fr.wr;
  assign set_mask  = (wr_commit && is_cmd) ? byte_lane_mask(fr.addr[0], fr.data) : '0;
  assign clr_req   = |(set_mask & CLR_MASK);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      reg_wr_en   <= 1'b0;
      reg_wr_idx  <= '0;
      reg_wr_hi   <= 1'b0;
      reg_wr_byte <= '0;
      rd_idx_q    <= '0;
      ld_en       <= 1'b0;
      cmd_pend    <= '0;
      cmd_start   <= '0;
      err_len     <= 1'b0;
      err_busy    <= 1'b0;
    end else begin
      reg_wr_en <= wr_commit & is_mapped;
      if (wr_commit) begin
        reg_wr_idx  <= widx;
        reg_wr_hi   <= fr.addr[0];
        reg_wr_byte <= fr.data;
      end
      if (frame_done && !fr.wr) rd_idx_q <= widx;
      ld_en     <= frame_done | cs_fall;
      cmd_pend  <= (cmd_pend & ~cmd_done) | (set_mask & ~CLR_MASK);
      cmd_start <= set_mask;
      err_len   <= len_bad | (err_len & ~clr_req);
      err_busy  <= (cs_active & capture_busy) | (err_busy & ~clr_req);
    end

  assign reg_rd_idx = rd_idx_q;
  always_comb begin
    if (rd_idx_q == CMD_IDX)      ld_word = cmd_pend;
    else if (rd_idx_q < NUM_IDX)  ld_word = reg_rd_data;
    else                          ld_word = '0;
  end

  assert_wr_in_map_R10: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |-> (reg_wr_idx < NUM_IDX) && (reg_wr_idx != CMD_IDX));
  assert_pend_needs_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(cmd_pend) & ~cmd_pend) & ~$past(cmd_done)) == '0));
  assert_len_err_at_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_len) |-> !cs_active);
  assert_busy_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_active && capture_busy) |=> err_busy);
endmodule

// File: rtl/spi_regslave.sv
`timescale 1ns/1ps
module spi_regslave
  import spi_regslave_pkg::*;
#(
  parameter int NUM_WORDS   = 24,
  parameter int CMD_WORD    = 31,
  parameter int CLR_BIT     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              sdi,
  output logic              sdo,
  input  logic              capture_busy,
  input  logic [WORD_W-1:0] cmd_done,
  output logic [WORD_W-1:0] cmd_start,
  output logic              err_len,
  output logic              err_busy,
  output logic              reg_wr_en,
  output logic [WIDX_W-1:0] reg_wr_idx,
  output logic              reg_wr_hi,
  output logic [BYTE_W-1:0] reg_wr_byte,
  output logic [WIDX_W-1:0] reg_rd_idx,
  input  logic [WORD_W-1:0] reg_rd_data
);
  logic [2:0]        pins_s;
  logic              frame_done, cs_fall, len_bad, cs_active, sdo_bit, ld_en;
  logic [WORD_W-1:0] frame_word, ld_word;

  spi_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({sclk, cs_n, sdi}), .q(pins_s));

  spi_frame_shift u_shift (
    .clk(clk), .rst_n(rst_n),
    .sclk_s(pins_s[2]), .cs_n_s(pins_s[1]), .sdi_s(pins_s[0]),
    .ld_en(ld_en), .ld_word(ld_word),
    .frame_done(frame_done), .frame_word(frame_word),
    .cs_fall(cs_fall), .len_bad(len_bad), .cs_active(cs_active),
    .sdo_bit(sdo_bit));

  spi_reg_decode #(.NUM_WORDS(NUM_WORDS), .CMD_WORD(CMD_WORD), .CLR_BIT(CLR_BIT)) u_dec (
    .clk(clk), .rst_n(rst_n),
    .frame_done(frame_done), .frame_word(frame_word),
    .cs_fall(cs_fall), .len_bad(len_bad), .cs_active(cs_active),
    .capture_busy(capture_busy), .cmd_done(cmd_done), .reg_rd_data(reg_rd_data),
    .reg_wr_en(reg_wr_en), .reg_wr_idx(reg_wr_idx), .reg_wr_hi(reg_wr_hi),
    .reg_wr_byte(reg_wr_byte), .reg_rd_idx(reg_rd_idx),
    .cmd_start(cmd_start), .err_len(err_len), .err_busy(err_busy),
    .ld_en(ld_en), .ld_word(ld_word));

  // R5: released line follows the raw select so no sync lag shows on the pin
  assign sdo = cs_n ? 1'bz : sdo_bit;
endmodule

// File: tb/spi_regslave_tb.sv
`timescale 1ns/1ps
module spi_regslave_tb_top;
  localparam int NW = 24;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b1, cs_n = 1'b1, sdi = 1'b0, capture_busy = 1'b0;
  logic [15:0] cmd_done = '0;
  wire         sdo;
  logic [15:0] cmd_start, reg_rd_data;
  logic        err_len, err_busy, reg_wr_en, reg_wr_hi;
  logic [5:0]  reg_wr_idx, reg_rd_idx;
  logic [7:0]  reg_wr_byte;

  logic [15:0] mem [NW];
  logic [15:0] expv [NW];
  int total = 0, bad = 0, wr_cnt = 0, start11_cnt = 0;
  logic [15:0] last_start = '0;

  always #4 clk = ~clk;

  spi_regslave dut_i (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdi(sdi), .sdo(sdo),
    .capture_busy(capture_busy), .cmd_done(cmd_done), .cmd_start(cmd_start),
    .err_len(err_len), .err_busy(err_busy), .reg_wr_en(reg_wr_en),
    .reg_wr_idx(reg_wr_idx), .reg_wr_hi(reg_wr_hi), .reg_wr_byte(reg_wr_byte),
    .reg_rd_idx(reg_rd_idx), .reg_rd_data(reg_rd_data));

  // external register-file model
  assign reg_rd_data = (int'(reg_rd_idx) < NW) ? mem[reg_rd_idx] : 16'hDEAD;
  always @(posedge clk) begin
    if (reg_wr_en && int'(reg_wr_idx) < NW) begin
      if (reg_wr_hi) mem[reg_wr_idx][15:8] <= reg_wr_byte;
      else           mem[reg_wr_idx][7:0]  <= reg_wr_byte;
    end
    if (reg_wr_en) wr_cnt++;
    if (cmd_start[11]) start11_cnt++;
    if (cmd_start != 0) last_start <= cmd_start;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic [31:0] d, input int n, output logic [31:0] r);
    r = '0;
    @(negedge clk); cs_n = 1'b0;
    repeat (10) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      sclk = 1'b0; sdi = d[n-1-i];
      repeat (HALF) @(negedge clk);
      r = {r[30:0], sdo};
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
    end
    repeat (6) @(negedge clk); cs_n = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  task automatic frame(input logic [15:0] w, output logic [15:0] r);
    logic [31:0] rr;
    xfer({16'h0, w}, 16, rr);
    r = rr[15:0];
  endtask

  function automatic logic [15:0] rd_cmd(input logic [6:0] a); return {1'b0, a, 8'h00}; endfunction
  function automatic logic [15:0] wr_cmd(input logic [6:0] a, input logic [7:0] b); return {1'b1, a, b}; endfunction

  task automatic t_reset;
    logic [15:0] r;
    chk("R5 idle z", {31'h0, sdo}, {31'h0, 1'bz});
    chk("R11 err_len", {31'h0, err_len}, 0);
    chk("R11 err_busy", {31'h0, err_busy}, 0);
    chk("R11 cmd_start", {16'h0, cmd_start}, 0);
    frame(rd_cmd(7'h3E), r);
    chk("R4 first frame word0", {16'h0, r}, {16'h0, expv[0]});
    frame(rd_cmd(7'h3E), r);
    chk("R11 command word zero", {16'h0, r}, 0);
  endtask

  task automatic t_write_bytes;
    logic [15:0] r; int c0;
    c0 = wr_cnt;
    frame(wr_cmd(7'h04, 8'h5A), r); expv[2][7:0] = 8'h5A;
    frame(wr_cmd(7'h05, 8'hC3), r); expv[2][15:8] = 8'hC3;
    chk("R2 two write pulses", wr_cnt - c0, 2);
    frame(rd_cmd(7'h04), r);
    frame(rd_cmd(7'h05), r);
    chk("R3 even address word", {16'h0, r}, {16'h0, expv[2]});
    frame(rd_cmd(7'h05), r);
    chk("R3 odd address same word", {16'h0, r}, {16'h0, expv[2]});
  endtask

  task automatic t_pipeline;
    logic [15:0] r;
    frame(rd_cmd(7'h06), r);
    frame(wr_cmd(7'h0A, 8'h11), r); expv[5][7:0] = 8'h11;
    chk("R4 write frame returns last read", {16'h0, r}, {16'h0, expv[3]});
    frame(wr_cmd(7'h0B, 8'h22), r); expv[5][15:8] = 8'h22;
    chk("R4 second write still last read", {16'h0, r}, {16'h0, expv[3]});
    frame(rd_cmd(7'h0A), r);
    frame(rd_cmd(7'h0A), r);
    chk("R2 both lanes landed", {16'h0, r}, {16'h0, expv[5]});
  endtask

  task automatic t_unmapped;
    logic [15:0] r; int c0;
    c0 = wr_cnt;
    frame(wr_cmd(7'h30, 8'h77), r);
    chk("R10 unmapped write no pulse", wr_cnt - c0, 0);
    frame(rd_cmd(7'h31), r);
    frame(rd_cmd(7'h40), r);
    chk("R10 unmapped reads zero", {16'h0, r}, 0);
    frame(rd_cmd(7'h00), r);
    chk("R10 second unmapped zero", {16'h0, r}, 0);
  endtask

  task automatic t_cmd;
    logic [15:0] r; int s0;
    s0 = start11_cnt;
    frame(16'hBF08, r);
    chk("R8 one start pulse", start11_cnt - s0, 1);
    chk("R8 start bit 11 only", {16'h0, last_start}, 32'h0800);
    frame(rd_cmd(7'h3F), r);
    frame(rd_cmd(7'h3E), r);
    chk("R8 pending bit11", {16'h0, r}, 32'h0800);
    @(negedge clk); cmd_done[11] = 1'b1; @(negedge clk); cmd_done[11] = 1'b0;
    frame(rd_cmd(7'h3E), r);
    chk("R8 cleared by done", {16'h0, r}, 0);
  endtask

  task automatic t_cmd_race;
    logic [15:0] r;
    cmd_done[11] = 1'b1;
    repeat (4) @(negedge clk);
    fork
      frame(16'hBF08, r);
      begin
        do @(negedge clk); while (!cmd_start[11]);
        cmd_done[11] = 1'b0;
      end
    join
    frame(rd_cmd(7'h3E), r);
    frame(rd_cmd(7'h3E), r);
    chk("R8 set wins over done", {16'h0, r}, 32'h0800);
    @(negedge clk); cmd_done[11] = 1'b1; @(negedge clk); cmd_done[11] = 1'b0;
  endtask

  task automatic t_len;
    logic [31:0] rr; logic [15:0] r; int c0;
    c0 = wr_cnt;
    xfer({16'h0, wr_cmd(7'h08, 8'hEE)} >> 6, 10, rr);
    chk("R6 short frame flagged", {31'h0, err_len}, 1);
    chk("R6 short frame no write", wr_cnt - c0, 0);
    frame(16'hBE10, r);
    chk("R9 clear err_len", {31'h0, err_len}, 0);
    frame(rd_cmd(7'h3E), r);
    frame(rd_cmd(7'h3E), r);
    chk("R9 clear bit not pending", {16'h0, r}, 0);
    xfer({rd_cmd(7'h04), rd_cmd(7'h04)}, 32, rr);
    chk("R1 back-to-back frames word", {16'h0, rr[15:0]}, {16'h0, expv[2]});
    chk("R6 32 edges no error", {31'h0, err_len}, 0);
  endtask

  task automatic t_busy;
    logic [15:0] r;
    capture_busy = 1'b1;
    frame(rd_cmd(7'h02), r);
    chk("R7 busy access flagged", {31'h0, err_busy}, 1);
    frame(16'hBE10, r);
    chk("R9 set wins over clear", {31'h0, err_busy}, 1);
    capture_busy = 1'b0;
    frame(16'hBE10, r);
    chk("R9 clear err_busy", {31'h0, err_busy}, 0);
  endtask

  task automatic t_tristate;
    @(negedge clk); cs_n = 1'b0;
    repeat (10) @(negedge clk);
    chk("R5 driven when selected", {31'h0, (sdo === 1'bz)}, 0);
    cs_n = 1'b1; #1;
    chk("R5 z when released", {31'h0, sdo}, {31'h0, 1'bz});
    repeat (10) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < NW; i++) begin
      mem[i]  = 16'hA000 + 16'(i) * 16'h0111;
      expv[i] = 16'hA000 + 16'(i) * 16'h0111;
    end
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    fork
      begin
        t_reset; t_write_bytes; t_pipeline; t_unmapped;
        t_cmd; t_cmd_race; t_len; t_busy; t_tristate;
      end
      begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule